// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes stereo audio from a three-wire serial link and turns it into parallel samples. The three wires are a bit clock, a word clock and a data line. All three are oversampled in the system clock domain. Data arrives MSB first and is taken on each rising bit-clock edge. In right-justified framing the useful word sits against the end of its channel slot, so the final data bit comes just before the word clock toggles. The receiver keeps the most recent bits of each slot. When the word clock changes level, it treats the slot as complete and outputs the last N bits as the sample.

N comes from a 6-bit width setting and is limited to 24. The sample is sign-extended to 24 bits. It is presented with a one-cycle valid strobe and a flag that tells left from right. A slot that holds fewer bit-clock periods than N produces a one-cycle error pulse in place of a sample. A mode input turns the receiver on and off. The width setting only has meaning while the mode input is high.

Control is a three-state machine:

| State | Meaning |
|---|---|
| `ST_OFF` | Idle |
| `ST_SYNC` | Waiting for the first word-clock change |
| `ST_RUN` | Emitting one result per completed slot |

Transitions:

| Transition | Condition |
|---|---|
| `ST_OFF` → `ST_SYNC` | Mode goes high |
| `ST_SYNC` → `ST_RUN` | First word-clock change seen on a bit-clock rise |
| `ST_SYNC` → `ST_OFF` | Mode goes low |
| `ST_RUN` → `ST_OFF` | Mode goes low |

Every other case holds the current state.

Top module: `rj_rx_top`

## Requirements
- R1: After reset, `sample_valid`, `slot_err`, `sample_right` and `sample_data` are all zero.
- R2: On a word-clock change, the sample holds the last N data bits taken on rising bit-clock edges before that change, with the last bit as the LSB. N is the effective width. Earlier bits of the slot are ignored.
- R3: The sample is sign-extended from bit N-1 to 24 bits.
- R4: `sample_right` is 0 for a slot sent with the word clock low (left) and 1 for a slot sent with it high (right).
- R5: A width setting above 24 is treated as 24.
- R6: A width setting of 0 yields a valid sample equal to zero.
- R7: A slot with fewer bit-clock rises than N raises `slot_err` for one cycle, and `sample_valid` stays low for that slot. A slot with exactly N rises is valid.
- R8: After reset or re-enable, the slot in progress at the first word-clock change is discarded, with neither valid nor error.
- R9: While `rj_mode` is low, neither `sample_valid` nor `slot_err` is raised, whatever the serial inputs do.
- R10: `sample_valid` and `slot_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rj_mode | input | 1 | Enables right-justified reception |
| cfg_width | input | 6 | Useful bits per word, clamped to 24 |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock, low = left, high = right |
| sdin | input | 1 | Serial data, MSB first |
| sample_data | output | 24 | Sign-extended sample |
| sample_right | output | 1 | Channel of the sample, 1 = right |
| sample_valid | output | 1 | One-cycle strobe for a good sample |
| slot_err | output | 1 | One-cycle strobe for a too-short slot |

## Verification
The bench sends slots longer than the width. A receiver that kept the first N bits instead of the last N returns the wrong value for these slots. It also sends negative samples at several widths, which catches sign extension taken from a fixed bit. Slots exactly N bits long, and slots two bits short, probe the off-by-one at the error threshold. A reversed comparison there would either flag good slots or pass short ones. Width settings of 40 and 0 check the clamp and the empty word. A receiver that did not discard the first partial slot after re-enable, or that kept emitting while disabled, produces an extra result that the reference queue does not expect.

// File: rtl/rj_rx_pkg.sv
package rj_rx_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } rx_state_t;

    localparam int unsigned SAMPLE_BITS = 24;

endpackage

// File: rtl/rj_edge_detect.sv
module rj_edge_detect #(
    parameter int unsigned IN_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic wclk,
    input  logic sdin,
    output logic bit_rise,
    output logic ws_s,
    output logic sd_s
);
    localparam int unsigned LANES = 3;

    logic [LANES-1:0] stage [IN_STAGES];
    logic             bclk_last;
    logic [LANES-1:0] tail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(IN_STAGES); k++) stage[k] <= '0;
            bclk_last <= 1'b0;
        end else begin
            stage[0] <= {bclk, wclk, sdin};
            for (int k = 1; k < int'(IN_STAGES); k++) stage[k] <= stage[k-1];
            bclk_last <= stage[IN_STAGES-1][2];
        end
    end

    assign tail     = stage[IN_STAGES-1];
    assign bit_rise = tail[2] & ~bclk_last;
    assign ws_s     = tail[1];
    assign sd_s     = tail[0];

    // R10: a rise needs a low sample first, so two rises never abut
    a_r10_rise_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |=> !bit_rise);

endmodule

// File: rtl/rj_shift_track.sv
module rj_shift_track #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              ws_s,
    input  logic              sd_s,
    output logic [WORD_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              ws_prev,
    output logic              word_edge
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign word_edge = bit_rise && (ws_s != ws_prev);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            ws_prev <= 1'b0;
        end else if (bit_rise) begin
            shreg   <= {shreg[WORD_W-2:0], sd_s};
            ws_prev <= ws_s;
            if (ws_s != ws_prev)
                bit_cnt <= CNT_W'(1);
            else if (bit_cnt != CNT_MAX)
                bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    // R2: a new slot starts counting from its first bit
    a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        word_edge |=> (bit_cnt == CNT_W'(1)));

endmodule

// File: rtl/rj_word_extract.sv
module rj_word_extract #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned CFG_W  = 6
) (
    input  logic [CFG_W-1:0]  cfg_width,
    input  logic [WORD_W-1:0] shreg,
    output logic [CFG_W-1:0]  eff_width,
    output logic [WORD_W-1:0] word
);
    localparam logic [CFG_W-1:0] WIDTH_CAP = CFG_W'(WORD_W);

    logic sign;

    always_comb begin
        eff_width = (cfg_width > WIDTH_CAP) ? WIDTH_CAP : cfg_width;
        sign = 1'b0;
        for (int i = 0; i < int'(WORD_W); i++)
            if (i == int'(eff_width) - 1) sign = shreg[i];
        for (int i = 0; i < int'(WORD_W); i++)
            word[i] = (i < int'(eff_width)) ? shreg[i] : sign;
    end

endmodule

// File: rtl/rj_rx_top.sv
module rj_rx_top
    import rj_rx_pkg::*;
#(
    parameter int unsigned WORD_W    = SAMPLE_BITS,
    parameter int unsigned CFG_W     = 6,
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned IN_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rj_mode,
    input  logic [CFG_W-1:0]  cfg_width,
    input  logic              bclk,
    input  logic              wclk,
    input  logic              sdin,
    output logic [WORD_W-1:0] sample_data,
    output logic              sample_right,
    output logic              sample_valid,
    output logic              slot_err
);
    rx_state_t         state, state_nx;
    logic              bit_rise, ws_s, sd_s;
    logic [WORD_W-1:0] shreg, word;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CFG_W-1:0]  eff_width;
    logic              ws_prev, word_edge, slot_done, slot_full;

    rj_edge_detect #(.IN_STAGES(IN_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdin(sdin),
        .bit_rise(bit_rise), .ws_s(ws_s), .sd_s(sd_s)
    );

    rj_shift_track #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .ws_s(ws_s),
        .sd_s(sd_s), .shreg(shreg), .bit_cnt(bit_cnt), .ws_prev(ws_prev),
        .word_edge(word_edge)
    );

    rj_word_extract #(.WORD_W(WORD_W), .CFG_W(CFG_W)) u_extract (
        .cfg_width(cfg_width), .shreg(shreg), .eff_width(eff_width),
        .word(word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (rj_mode) state_nx = ST_SYNC;
            ST_SYNC: if (!rj_mode) state_nx = ST_OFF;
                     else if (word_edge) state_nx = ST_RUN;
            ST_RUN:  if (!rj_mode) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    assign slot_done = (state == ST_RUN) && rj_mode && word_edge;
    assign slot_full = int'(bit_cnt) >= int'(eff_width);

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_data  <= '0;
            sample_right <= 1'b0;
            sample_valid <= 1'b0;
            slot_err     <= 1'b0;
        end else begin
            sample_valid <= slot_done && slot_full;
            slot_err     <= slot_done && !slot_full;
            if (slot_done && slot_full) begin
                sample_data  <= word;
                sample_right <= ws_prev;
            end
        end
    end

    // R10: the two strobes exclude each other
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_valid && slot_err));
    // R10: valid lasts one cycle
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
    // R7: error lasts one cycle
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |=> !slot_err);
    // R9: disabled receiver stays silent
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rj_mode |=> !(sample_valid || slot_err));
    // R6: zero width gives a zero sample
    a_r6_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && $past(cfg_width) == '0) |-> (sample_data == '0));

endmodule

// File: tb/tb_rj_rx_top.sv
module tb_rj_rx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rj_mode = 1'b0;
    logic [5:0]  cfg_width = 6'd16;
    logic        bclk = 1'b0, wclk = 1'b0, sdin = 1'b0;
    logic [23:0] sample_data;
    logic        sample_right, sample_valid, slot_err;

    always #4 clk = ~clk;

    rj_rx_top dut (
        .clk(clk), .rst_n(rst_n), .rj_mode(rj_mode), .cfg_width(cfg_width),
        .bclk(bclk), .wclk(wclk), .sdin(sdin), .sample_data(sample_data),
        .sample_right(sample_right), .sample_valid(sample_valid),
        .slot_err(slot_err)
    );

    typedef struct {
        bit          is_err;
        bit          right;
        logic [23:0] data;
        string       tag;
    } ev_t;

    ev_t   expq[$];
    int    checks = 0;
    int    errors = 0;
    string phase = "R2";
    bit    done = 0;

    // behavioural reference state
    bit          m_prev = 0;
    bit          m_synced = 0;
    int          m_cnt = 0;
    logic [63:0] m_hist = '0;

    function automatic void model_bit(input bit w, input bit b);
        int          n;
        longint      v;
        ev_t         e;
        if (!rj_mode) m_synced = 0;
        if (w != m_prev) begin
            if (rj_mode) begin
                if (m_synced) begin
                    n = (cfg_width > 24) ? 24 : int'(cfg_width);
                    e.right = m_prev;
                    e.tag   = phase;
                    e.is_err = (m_cnt < n);
                    v = (n == 0) ? 0 : longint'(m_hist & ((64'd1 << n) - 1));
                    if (n > 0 && m_hist[n-1]) v = v - (longint'(1) << n);
                    e.data = e.is_err ? 24'd0 : v[23:0];
                    expq.push_back(e);
                end else m_synced = 1;
            end
            m_cnt = 1;
            m_hist = {63'd0, b};
        end else begin
            m_cnt++;
            m_hist = {m_hist[62:0], b};
        end
        m_prev = w;
    endfunction

    task automatic send_bit(input bit w, input bit b);
        @(negedge clk);
        wclk = w; sdin = b; bclk = 1'b0;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        model_bit(w, b);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_slot(input bit w, input logic [63:0] word, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w, word[i]);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sample_valid && slot_err)
                check(0, "R10", "both strobes", 1, 0);
            if (sample_valid || slot_err) begin
                if (expq.size() == 0) begin
                    check(0, phase, "unexpected strobe (R8/R9)", 1, 0);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    check(slot_err == e.is_err, e.tag, "err vs valid",
                          slot_err, e.is_err);
                    if (!e.is_err) begin
                        check(sample_data == e.data, e.tag, "sample",
                              sample_data, e.data);
                        check(sample_right == e.right, "R4", "channel",
                              sample_right, e.right);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", "timeout", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sample_valid == 0 && slot_err == 0 && sample_right == 0
              && sample_data == 0, "R1", "reset outputs",
              {sample_valid, slot_err, sample_right, sample_data}, 0);
        rj_mode = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: the partial first slot is dropped
        phase = "R8";
        send_slot(0, 64'h5, 3);
        send_slot(1, 64'h1234, 16);
        phase = "R2";
        send_slot(0, 64'h7ABC, 16);
        send_slot(1, 64'h8001, 16);       // R3 negative
        send_slot(0, 64'hFF_0F0F, 24);    // R2 extra leading bits dropped
        phase = "R3";
        send_slot(1, 64'hC0DE_9876, 32);
        cfg_width = 6'd24;
        send_slot(0, 64'hA5_123456, 32);
        send_slot(1, 64'h00_800000, 24);

        // R5: width above 24 clamps
        phase = "R5";
        cfg_width = 6'd40;
        send_slot(0, 64'hDEAD_BEEF, 32);
        send_slot(1, 64'h12_7FFFFF, 32);
        cfg_width = 6'd63;
        send_slot(0, 64'h3_FEDCBA, 26);

        // R6: zero width
        phase = "R6";
        cfg_width = 6'd0;
        send_slot(1, 64'hFFFF, 16);
        send_slot(0, 64'h1, 4);

        // R7: short and exact slots
        phase = "R7";
        cfg_width = 6'd20;
        send_slot(1, 64'h3FFFF, 18);
        send_slot(0, 64'hFFFFF, 20);
        send_slot(1, 64'h4_5678, 19);
        send_slot(0, 64'h9_ABCD, 20);
        cfg_width = 6'd1;
        send_slot(1, 64'h1, 1);
        send_slot(0, 64'h0, 1);

        // R9: disabled, then R8 resync after enabling
        phase = "R9";
        cfg_width = 6'd12;
        repeat (4) @(negedge clk);
        rj_mode = 1'b0;
        repeat (4) @(negedge clk);
        send_slot(1, 64'hABC, 12);
        send_slot(0, 64'h123, 12);
        send_slot(1, 64'h3, 2);
        send_slot(0, 64'hFFF, 12);
        rj_mode = 1'b1;
        repeat (4) @(negedge clk);
        phase = "R8";
        send_slot(0, 64'h77, 8);
        send_slot(1, 64'h800, 12);
        phase = "R2";
        send_slot(0, 64'hF7FF, 16);
        send_slot(1, 64'h0, 12);
        repeat (20) @(negedge clk);

        check(expq.size() == 0, "R2", "results still pending",
              expq.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule